// File: doc/BRIEF.md
# Signed Decimal Field Adder

This block adds or subtracts two signed decimal fields that live in a digit-addressed memory and overwrites the destination field (P) with the result. Each memory word holds one decimal digit and one flag bit. A field is named by the address of its units digit and runs toward lower addresses. It ends at the first digit above the units position whose flag is set. The flag on the units digit is the field's sign.

The block works one digit position per step. In each step it reads a P digit and a Q digit, adds them, and writes the sum back over the P digit. When the signs make the operation an effective subtraction, Q is complemented on the fly. If that addition ends without a carry out of the top digit, the stored result is inverted. A second pass then re-reads P from the units digit, tens-complements it, and flips the sign.

When the operation finishes, the block updates a positive indicator and a zero indicator. It also keeps two sticky flags: one for overflow and one for non-numeric digits.

The memory port is a request channel with valid/ready handshaking, plus an unstalled response channel. While `mem_req_valid` is high and `mem_req_ready` is low, the request must hold steady: address, write enable and write data do not change. A read request is answered by `mem_rsp_valid` in the cycle after the request is accepted. The block always takes that response. Control pins are plain levels or pulses.

Top module: `dfa_field_adder`

## Requirements
- R1: A field starts at the address given for its units digit and is processed toward lower addresses. P processing stops after the first digit above the units position whose flag is set. Decrementing from address 0 wraps to MEM_DEPTH-1. No memory word outside the P field is written, and writes happen in descending address order.
- R2: A memory word is {flag, value}: bit 4 is the flag and bits 3..0 hold the value 0..9. A set flag on the units digit means the field is negative.
- R3: If op_sub=0, the result is P+Q. If op_sub=1, the result is P−Q. The result is written as a signed decimal into the P field. Q is complement-added when the effective operation is a subtraction, and true-added otherwise.
- R4: If the complement add ends without a carry out of the top P digit, a recomplement pass rewrites P as the correct magnitude and inverts P's sign.
- R5: ind_ovf is set by a carry out of the top P digit on a true add, or by a Q field longer than P. It is not set by a carry on a complement add. It is not cleared by start, and only reset clears it.
- R6: If Q is shorter than P, zeros are supplied for the missing high-order digits. If Q is longer, only its low Dp digits are used.
- R7: From start until done, ind_pos and ind_zero both read 1. At done, ind_zero=1 for a zero result, and ind_pos=1 for a positive nonzero result. A zero result keeps P's original sign.
- R8: After the operation, the top P digit still carries its flag, and the digits between the units and top positions carry none.
- R9: With mem_req_ready held high, done pulses 5·Dp+1 cycles after the start edge, or 8·Dp+1 cycles when a recomplement pass runs. busy is high for exactly those cycles.
- R10: A request holds steady while it is stalled. A read response arrives one cycle after the read is accepted.
- R11: A value of 10..15 in either field is treated as zero and sets the sticky err output, which only reset clears.
- R12: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | begin an operation (one-cycle pulse) |
| op_sub | input | 1 | 1 = subtract Q from P, 0 = add |
| p_addr | input | ADDR_W | units-digit address of P (destination) |
| q_addr | input | ADDR_W | units-digit address of Q |
| busy | output | 1 | operation in progress |
| done | output | 1 | one-cycle completion pulse |
| mem_req_valid | output | 1 | memory request valid |
| mem_req_ready | input | 1 | memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | request address |
| mem_req_wdata | output | 5 | write word {flag, value} |
| mem_rsp_valid | input | 1 | read data valid |
| mem_rsp_data | input | 5 | read word {flag, value} |
| ind_pos | output | 1 | result positive and nonzero |
| ind_zero | output | 1 | result zero |
| ind_ovf | output | 1 | sticky overflow |
| err | output | 1 | sticky non-numeric digit seen |

## Verification
With ready held high, done is due 5·Dp+1 cycles after the start edge, or 8·Dp+1 cycles with a recomplement pass. The bench counts the cycles from the start edge and compares the count with that figure. The indicators and sticky flags are sampled in the done cycle. The bench computes the expected write addresses when the start is given. Every accepted write is compared, in the cycle it is accepted, against the next address in that list. Memory contents are compared once done has been seen. Other runs stall ready at random, so that a request held across a stall is also exercised.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
  localparam int WORD_W = 5;

  typedef struct packed {
    logic       flag;
    logic [3:0] val;
  } dword_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_P, S_WT_P, S_RD_Q, S_WT_Q, S_WR,
    S_RC_RD, S_RC_WT, S_RC_WR, S_FIN
  } dfa_state_e;
endpackage

// File: rtl/dfa_addr_dec.sv
module dfa_addr_dec #(
  parameter int ADDR_W    = 15,
  parameter int MEM_DEPTH = 20000
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(MEM_DEPTH - 1);
  generate
    if (MEM_DEPTH == (1 << ADDR_W)) begin : g_pow2
      assign addr_out = addr_in - 1'b1;
    end else begin : g_wrap
      assign addr_out = (addr_in == '0) ? TOP : addr_in - 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dfa_digit_alu.sv
module dfa_digit_alu (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  input  logic       comp_b,
  output logic [3:0] sum,
  output logic       cout,
  output logic       a_bad,
  output logic       b_bad
);
  logic [3:0] a_n, b_n, b_e;
  logic [4:0] raw;

  always_comb begin
    a_bad = (a > 4'd9);
    b_bad = (b > 4'd9);
    a_n   = a_bad ? 4'd0 : a;
    b_n   = b_bad ? 4'd0 : b;
    b_e   = comp_b ? (4'd9 - b_n) : b_n;
    raw   = {1'b0, a_n} + {1'b0, b_e} + {4'd0, cin};
    cout  = (raw >= 5'd10);
    sum   = cout ? 4'(raw - 5'd10) : raw[3:0];
  end
endmodule

// File: rtl/dfa_status.sv
module dfa_status (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic done,
  input  logic start_acc,
  input  logic fin_set,
  input  logic fin_zero,
  input  logic fin_sign,
  input  logic ovf_set,
  input  logic err_set,
  output logic ind_pos,
  output logic ind_zero,
  output logic ind_ovf,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ind_pos  <= 1'b0;
      ind_zero <= 1'b0;
      ind_ovf  <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (start_acc) begin
        ind_pos  <= 1'b1;
        ind_zero <= 1'b1;
      end else if (fin_set) begin
        ind_pos  <= !fin_zero && !fin_sign;
        ind_zero <= fin_zero;
      end
      if (ovf_set) ind_ovf <= 1'b1;
      if (err_set) err <= 1'b1;
    end
  end

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ind_ovf |=> ind_ovf);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_ind_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> (ind_pos && ind_zero));
  p_ind_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(ind_pos && ind_zero));
endmodule

// File: rtl/dfa_ctrl.sv
module dfa_ctrl
  import dfa_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int MEM_DEPTH = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_sub,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              busy,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              start_acc,
  output logic              fin_set,
  output logic              fin_zero,
  output logic              fin_sign,
  output logic              ovf_set,
  output logic              err_set
);
  localparam int NPTR = 2;

  dfa_state_e        state;
  logic [ADDR_W-1:0] ptr    [NPTR];
  logic [ADDR_W-1:0] ptr_m1 [NPTR];
  logic [ADDR_W-1:0] units_addr;
  dword_t            p_word, q_word;
  logic              units, q_end, carry, comp_r, sign_p, op_sub_r, nz;

  genvar gi;
  generate
    for (gi = 0; gi < NPTR; gi++) begin : g_ptr
      dfa_addr_dec #(.ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH)) u_dec (
        .addr_in (ptr[gi]),
        .addr_out(ptr_m1[gi])
      );
    end
  endgenerate

  logic       in_rc, comp_now, p_last, q_top, q_longer;
  logic [3:0] alu_a, alu_b, alu_sum;
  logic       alu_cin, alu_comp, alu_cout, a_bad, b_bad;
  logic       req_acc, wr_acc, rc_acc, res_nz;

  always_comb begin
    in_rc    = (state == S_RC_WR);
    comp_now = units ? (op_sub_r ^ (p_word.flag != q_word.flag)) : comp_r;
    p_last   = p_word.flag && !units;
    q_top    = q_word.flag && !units;
    q_longer = !q_end && !q_top;
    alu_a    = in_rc ? 4'd0 : p_word.val;
    alu_b    = in_rc ? p_word.val : q_word.val;
    alu_comp = in_rc ? 1'b1 : comp_now;
    alu_cin  = in_rc ? carry : (units ? comp_now : carry);
  end

  dfa_digit_alu u_alu (
    .a(alu_a), .b(alu_b), .cin(alu_cin), .comp_b(alu_comp),
    .sum(alu_sum), .cout(alu_cout), .a_bad(a_bad), .b_bad(b_bad)
  );

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = ptr[0];
    mem_req_wdata = '0;
    unique case (state)
      S_RD_P, S_RC_RD: mem_req_valid = 1'b1;
      S_RD_Q: begin
        mem_req_valid = !q_end;
        mem_req_addr  = ptr[1];
      end
      S_WR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_wdata = {p_word.flag, alu_sum};
      end
      S_RC_WR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_wdata = {units ? !p_word.flag : p_word.flag, alu_sum};
      end
      default: ;
    endcase
    req_acc = mem_req_valid && mem_req_ready;
    wr_acc  = (state == S_WR) && req_acc;
    rc_acc  = (state == S_RC_WR) && req_acc;
    res_nz  = nz || (alu_sum != 4'd0);
  end

  always_comb begin
    busy      = (state != S_IDLE);
    done      = (state == S_FIN);
    start_acc = (state == S_IDLE) && start;
    ovf_set   = wr_acc && p_last && ((!comp_now && alu_cout) || q_longer);
    err_set   = wr_acc && (a_bad || b_bad);
    fin_set   = 1'b0;
    fin_zero  = !res_nz;
    fin_sign  = sign_p;
    if (wr_acc && p_last && !(comp_now && !alu_cout)) fin_set = 1'b1;
    if (rc_acc && p_last) begin
      fin_set  = 1'b1;
      fin_sign = !sign_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ptr[0]     <= '0;
      ptr[1]     <= '0;
      units_addr <= '0;
      p_word     <= '0;
      q_word     <= '0;
      units      <= 1'b0;
      q_end      <= 1'b0;
      carry      <= 1'b0;
      comp_r     <= 1'b0;
      sign_p     <= 1'b0;
      op_sub_r   <= 1'b0;
      nz         <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          ptr[0]     <= p_addr;
          ptr[1]     <= q_addr;
          units_addr <= p_addr;
          op_sub_r   <= op_sub;
          units      <= 1'b1;
          q_end      <= 1'b0;
          nz         <= 1'b0;
          state      <= S_RD_P;
        end
        S_RD_P: if (req_acc) state <= S_WT_P;
        S_WT_P: if (mem_rsp_valid) begin
          p_word <= mem_rsp_data;
          state  <= S_RD_Q;
        end
        S_RD_Q: if (q_end || req_acc) state <= S_WT_Q;
        S_WT_Q: begin
          if (q_end) begin
            q_word <= '0;
            state  <= S_WR;
          end else if (mem_rsp_valid) begin
            q_word <= mem_rsp_data;
            state  <= S_WR;
          end
        end
        S_WR: if (req_acc) begin
          carry  <= alu_cout;
          nz     <= res_nz;
          units  <= 1'b0;
          ptr[0] <= ptr_m1[0];
          ptr[1] <= ptr_m1[1];
          if (q_top) q_end <= 1'b1;
          if (units) begin
            comp_r <= comp_now;
            sign_p <= p_word.flag;
          end
          if (!p_last) begin
            state <= S_RD_P;
          end else if (comp_now && !alu_cout) begin
            ptr[0] <= units_addr;
            units  <= 1'b1;
            carry  <= 1'b1;
            nz     <= 1'b0;
            state  <= S_RC_RD;
          end else begin
            state <= S_FIN;
          end
        end
        S_RC_RD: if (req_acc) state <= S_RC_WT;
        S_RC_WT: if (mem_rsp_valid) begin
          p_word <= mem_rsp_data;
          state  <= S_RC_WR;
        end
        S_RC_WR: if (req_acc) begin
          carry  <= alu_cout;
          nz     <= res_nz;
          units  <= 1'b0;
          ptr[0] <= ptr_m1[0];
          state  <= p_last ? S_FIN : S_RC_RD;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)));
  p_rsp_expected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (state == S_WT_P || state == S_WT_Q || state == S_RC_WT));
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(units_addr));
  p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (mem_req_wdata[3:0] <= 4'd9));
  p_rc_after_comp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RC_RD) |-> comp_r);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

// File: rtl/dfa_field_adder.sv
module dfa_field_adder #(
  parameter int ADDR_W    = 15,
  parameter int MEM_DEPTH = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_sub,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              busy,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [4:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [4:0]        mem_rsp_data,
  output logic              ind_pos,
  output logic              ind_zero,
  output logic              ind_ovf,
  output logic              err
);
  logic start_acc, fin_set, fin_zero, fin_sign, ovf_set, err_set;

  dfa_ctrl #(.ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH)) u_ctrl (
    .clk, .rst_n, .start, .op_sub, .p_addr, .q_addr, .busy, .done,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_data,
    .start_acc, .fin_set, .fin_zero, .fin_sign, .ovf_set, .err_set
  );

  dfa_status u_status (
    .clk, .rst_n, .busy, .done, .start_acc, .fin_set, .fin_zero, .fin_sign,
    .ovf_set, .err_set, .ind_pos, .ind_zero, .ind_ovf, .err
  );
endmodule

// File: tb/dfa_field_adder_tb.sv
module dfa_field_adder_tb;
  localparam int AW = 8;
  localparam int DEPTH = 200;

  logic clk = 0, rst_n = 0;
  logic start = 0, op_sub = 0;
  logic [AW-1:0] p_addr = '0, q_addr = '0;
  logic busy, done, mem_req_valid, mem_req_we, mem_rsp_valid = 0, mem_req_ready = 1;
  logic [AW-1:0] mem_req_addr;
  logic [4:0] mem_req_wdata, mem_rsp_data = '0;
  logic ind_pos, ind_zero, ind_ovf, err;

  int n_tests = 0, n_fail = 0;
  logic [4:0] mem [DEPTH];
  logic [4:0] snap [DEPTH];
  int exp_wr[$];
  bit rnd_ready = 0;
  bit m_ovf = 0, m_err = 0;

  always #4 clk = ~clk;

  dfa_field_adder #(.ADDR_W(AW), .MEM_DEPTH(DEPTH)) u_dut (
    .clk, .rst_n, .start, .op_sub, .p_addr, .q_addr, .busy, .done,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_data, .ind_pos, .ind_zero, .ind_ovf, .err
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model; every accepted write is compared against the expected order (R1)
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        if (exp_wr.size() == 0) chk(0, "R1 unexpected write", int'(mem_req_addr), -1);
        else begin
          int e;
          e = exp_wr.pop_front();
          chk(int'(mem_req_addr) == e, "R1 write address", int'(mem_req_addr), e);
        end
        mem[mem_req_addr] <= mem_req_wdata;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr];
      end
    end
  end

  always @(negedge clk) mem_req_ready <= rnd_ready ? 1'($urandom % 2) : 1'b1;

  function automatic int wrapd(int a, int k);
    return ((a - k) % DEPTH + DEPTH) % DEPTH;
  endfunction

  task automatic put_field(int addr, int len, longint val, bit neg);
    for (int i = 0; i < len; i++) begin
      mem[wrapd(addr, i)] = {(i == len - 1) || (i == 0 && neg), 4'(val % 10)};
      val = val / 10;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_ovf = 0;
    m_err = 0;
    @(negedge clk);
  endtask

  task automatic run_op(bit sub, int pa, int qa, bit rdy_rand, bit chk_time, bit extra_start);
    int plen, qlen, cyc;
    longint pv, qv, r, pw;
    bit sp, sq, eff, rc, sgn, bad;
    // model: scan both fields
    plen = 1; while (mem[wrapd(pa, plen)][4] == 1'b0) plen++;
    plen++;
    qlen = 1; while (mem[wrapd(qa, qlen)][4] == 1'b0) qlen++;
    qlen++;
    sp = mem[pa][4]; sq = mem[qa][4];
    pv = 0; qv = 0; pw = 1; bad = 0;
    for (int i = 0; i < plen; i++) begin
      int dp, dq;
      dp = int'(mem[wrapd(pa, i)][3:0]);
      if (dp > 9) begin dp = 0; bad = 1; end
      dq = 0;
      if (i < qlen) begin
        dq = int'(mem[wrapd(qa, i)][3:0]);
        if (dq > 9) begin dq = 0; bad = 1; end
      end
      pv += dp * pw; qv += dq * pw; pw *= 10;
    end
    eff = sub ? (sp == sq) : (sp != sq);
    rc = 0; sgn = sp;
    if (!eff) begin
      r = pv + qv;
      if (r >= pw) begin m_ovf = 1; r -= pw; end
    end else begin
      r = pv - qv;
      if (r < 0) begin r = -r; rc = 1; sgn = !sp; end
    end
    if (qlen > plen) m_ovf = 1;
    if (bad) m_err = 1;
    for (int i = 0; i < plen; i++) exp_wr.push_back(wrapd(pa, i));
    if (rc) for (int i = 0; i < plen; i++) exp_wr.push_back(wrapd(pa, i));
    for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];

    rnd_ready = rdy_rand;
    op_sub = sub; p_addr = AW'(pa); q_addr = AW'(qa); start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 3000) begin
      if (cyc == 2) begin
        chk(ind_pos && ind_zero, "R7 indicators preset while busy", {ind_pos, ind_zero}, 3);
      end
      if (extra_start && cyc == 3) begin
        p_addr = AW'(wrapd(pa, 40)); q_addr = AW'(wrapd(qa, 40)); op_sub = !sub; start = 1;
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk(done == 1'b1, "R9 done reached", done, 1);
    if (chk_time)
      chk(cyc == (rc ? 8 : 5) * plen + 1, "R9 cycles to done", cyc, (rc ? 8 : 5) * plen + 1);
    chk(ind_zero == (r == 0), "R7 zero indicator", ind_zero, r == 0);
    chk(ind_pos == (r != 0 && !sgn), "R7 positive indicator", ind_pos, r != 0 && !sgn);
    chk(ind_ovf == m_ovf, "R5 overflow", ind_ovf, m_ovf);
    chk(err == m_err, "R11 error flag", err, m_err);
    rnd_ready = 0;
    @(negedge clk);
    chk(busy == 1'b0, "R9 idle after done", busy, 0);
    chk(exp_wr.size() == 0, "R1 all writes seen", exp_wr.size(), 0);
    exp_wr.delete();
    // memory contents: P field result (R3 R4 R8), rest untouched (R1)
    begin
      longint v;
      int nbad;
      v = r; nbad = 0;
      for (int i = 0; i < plen; i++) begin
        logic [4:0] ew;
        ew = {(i == plen - 1) || (i == 0 && sgn), 4'(v % 10)};
        v = v / 10;
        if (mem[wrapd(pa, i)] != ew) begin
          nbad++;
          chk(0, "R3/R8 result digit", mem[wrapd(pa, i)], ew);
        end
        snap[wrapd(pa, i)] = ew;
      end
      n_tests++;
      for (int i = 0; i < DEPTH; i++)
        if (mem[i] !== snap[i]) begin
          nbad++;
          n_tests++; n_fail++;
          $display("FAIL R1 memory word %0d actual=%0d expected=%0d", i, mem[i], snap[i]);
        end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 5'd0;
    @(negedge clk); @(negedge clk);
    chk(busy == 0 && done == 0, "R9 reset busy", busy, 0);
    chk(ind_ovf == 0 && err == 0, "R5 reset sticky flags", {ind_ovf, err}, 0);
    chk(ind_pos == 0 && ind_zero == 0, "R7 reset indicators", {ind_pos, ind_zero}, 0);
    do_reset();
    chk(mem_req_valid == 0, "R10 no request at idle", mem_req_valid, 0);

    // R3 R6: +0123 + +045, shorter Q, exact timing
    put_field(50, 4, 123, 0); put_field(80, 3, 45, 0);
    run_op(0, 50, 80, 0, 1, 0);
    // R5: true-add carry out sets overflow
    put_field(60, 2, 95, 0); put_field(90, 2, 7, 0);
    run_op(0, 60, 90, 1, 0, 0);
    // R3: subtract, same sign, P > Q, complement carry no overflow change
    put_field(50, 3, 500, 0); put_field(80, 3, 123, 0);
    run_op(1, 50, 80, 1, 0, 0);
    // R4: recomplement pass with exact timing
    put_field(50, 3, 123, 0); put_field(80, 3, 500, 0);
    run_op(1, 50, 80, 0, 1, 0);
    // R7: zero result keeps negative sign of P; ovf remains set (R5 not cleared)
    put_field(50, 3, 45, 1); put_field(80, 3, 45, 0);
    run_op(0, 50, 80, 1, 0, 0);
    // R2 R3: negative plus negative
    put_field(50, 2, 27, 1); put_field(80, 2, 15, 1);
    run_op(0, 50, 80, 1, 0, 0);
    // R5 R6: Q longer than P after reset
    do_reset();
    put_field(60, 2, 12, 0); put_field(90, 4, 1234, 0);
    run_op(0, 60, 90, 0, 1, 0);
    // R6: short Q complemented with zero fill
    do_reset();
    put_field(50, 4, 1000, 0); put_field(80, 2, 1, 0);
    run_op(1, 50, 80, 1, 0, 0);
    chk(ind_ovf == 0, "R5 complement carry leaves overflow clear", ind_ovf, 0);
    // R1: field wrapping below address 0
    put_field(1, 3, 456, 0); put_field(120, 3, 111, 1);
    run_op(0, 1, 120, 1, 0, 0);
    // R11: non-numeric digit in Q treated as zero
    put_field(50, 3, 321, 0); put_field(80, 3, 100, 0);
    mem[79] = 5'd12;
    run_op(0, 50, 80, 0, 1, 0);
    // R12: start while busy ignored
    put_field(50, 3, 222, 0); put_field(80, 3, 333, 1);
    put_field(10, 3, 999, 0); put_field(40, 3, 999, 0);
    run_op(1, 50, 80, 0, 1, 1);
    // R4: recomplement under random stalls (R10)
    put_field(150, 5, 10, 1); put_field(170, 4, 9999, 1);
    run_op(1, 150, 170, 1, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule